// File: doc/BRIEF.md
# Selectable-Source Baud Rate Generator

This block makes the bit-period tick for a serial transmitter and receiver. A 2-bit select field picks the event stream it counts: every system clock cycle, an enable pulse from a clock pre-divider, rising edges of a slow clock, or rising edges of an external serial clock pin. The two slow inputs are asynchronous. Each passes through a two-flop synchronizer and a rising-edge detector, which turns it into single-cycle enable pulses in the system clock domain.

A 16-bit divisor sets the rate. In synchronous mode one baud tick is produced every divisor source events. In asynchronous mode the divisor output is the 16x oversampling tick for the receiver, and a 4-bit stage turns every sixteenth of those into a baud tick. When synchronous mode is combined with the external source, each synchronized pin edge becomes a baud tick and the divisor is not used. The block also drives a serial clock level and its output enable for a bidirectional clock pad.

The divider is a four-state machine. The next state is decoded from the configuration:
- MD_PASS: synchronous mode with the external source.
- MD_OFF: divisor 0.
- MD_BYPASS: divisor 1.
- MD_DIVIDE: any other divisor.

The machine moves directly to whichever state is decoded, from any state. Each change of state restarts the counters, and so does a divisor write strobe. In MD_OFF no ticks are made. In MD_BYPASS every source event is a tick. In MD_DIVIDE a down-counter reloads to divisor−1 at terminal count. In MD_PASS the synchronized pin edges are forwarded.

Top module: `baud_tick_gen`

## Requirements
- R1: The select field picks the source events: 00 every system clock cycle, 01 each cycle with `pre_div_en` high, 10 each synchronized rising edge of `slow_clk`, 11 each synchronized rising edge of `ext_clk`. Each rising edge yields exactly one single-cycle event.
- R2: With `sync_mode`=0 and a divisor of 2 or more, `over_tick` pulses once every CD source events and `baud_tick` pulses once every 16·CD source events. Every `baud_tick` coincides with an `over_tick`.
- R3: With `sync_mode`=1 and select 00, 01 or 10, `baud_tick` pulses once every CD source events and `over_tick` stays 0.
- R4: With `sync_mode`=1 and select 11, `baud_tick` pulses once per rising edge of `ext_clk`, whatever the divisor holds, including 0 and 1.
- R5: A divisor of 0, outside the R4 case, produces no `baud_tick` and no `over_tick`.
- R6: A divisor of 1 bypasses the counter, so every source event is a divider output. With `sync_mode`=1 and select 00, `baud_tick` is high on every cycle and `serial_clk_out` toggles every cycle.
- R7: A `div_wr` strobe restarts the count. With select 00, the first `baud_tick` is high in the cycle after the CD-th rising clock edge following the edge that samples `div_wr` (synchronous mode). In asynchronous mode it comes after the 16·CD-th edge.
- R8: `serial_clk_oe` equals `clk_out_en` AND NOT `src_sel[1]`, registered, so it follows its inputs one clock later.
- R9: In MD_DIVIDE with an even divisor, `serial_clk_out` is high for CD/2 of every CD source events, which gives a 50% duty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 2 | Source select: 00 system, 01 pre-divided enable, 10 slow clock, 11 external pin |
| sync_mode | input | 1 | 1 = synchronous (divide by CD), 0 = asynchronous (divide by 16·CD) |
| divisor | input | 16 | Divisor CD |
| div_wr | input | 1 | Divisor write strobe; restarts the count |
| clk_out_en | input | 1 | Request to drive the serial clock pad |
| pre_div_en | input | 1 | Pre-divided clock enable pulse, system clock domain |
| slow_clk | input | 1 | Slow clock, asynchronous |
| ext_clk | input | 1 | External serial clock pin, asynchronous |
| baud_tick | output | 1 | One-cycle bit-period tick |
| over_tick | output | 1 | One-cycle 16x oversampling tick (asynchronous mode only) |
| serial_clk_out | output | 1 | Serial clock level for the pad |
| serial_clk_oe | output | 1 | Pad output enable |

## Verification
The bench sweeps both divide modes over the three internal sources and divisors 1 to 4. It measures the spacing between ticks, which tells a wrong source multiplier apart from a missing factor of 16 or an off-by-one reload.

The external source is tried with divisors 0, 1 and 5 in synchronous mode, to show that the divisor is ignored there, and with divisor 2 in asynchronous mode, where the divisor does apply.

Further runs check the following:
- the latency from a divisor write, which separates a reload on write from waiting for terminal count;
- silence with divisor 0;
- the half-high duty of the serial clock for even divisors, and its toggling in bypass;
- the output-enable truth table over all select codes.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic [1:0] {
        SRC_SYS  = 2'b00,
        SRC_PRE  = 2'b01,
        SRC_SLOW = 2'b10,
        SRC_EXT  = 2'b11
    } src_sel_e;

    typedef enum logic [1:0] {
        MD_OFF    = 2'd0,
        MD_BYPASS = 2'd1,
        MD_DIVIDE = 2'd2,
        MD_PASS   = 2'd3
    } div_mode_e;

    function automatic div_mode_e pick_mode(input logic sync,
                                            input logic [1:0] sel,
                                            input logic is_zero,
                                            input logic is_one);
        div_mode_e m;
        if (sync && (sel == SRC_EXT)) m = MD_PASS;
        else if (is_zero)             m = MD_OFF;
        else if (is_one)              m = MD_BYPASS;
        else                          m = MD_DIVIDE;
        return m;
    endfunction

endpackage

// File: rtl/baud_edge_sync.sv
module baud_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R1

endmodule

// File: rtl/baud_src_select.sv
module baud_src_select
    import baud_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       pre_en,
    input  logic       slow_rise,
    input  logic       ext_rise,
    output logic       src_en
);
    always_comb begin
        unique case (src_sel_e'(sel))
            SRC_SYS:  src_en = 1'b1;
            SRC_PRE:  src_en = pre_en;
            SRC_SLOW: src_en = slow_rise;
            SRC_EXT:  src_en = ext_rise;
            default:  src_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/baud_divider.sv
module baud_divider
    import baud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  div_mode_e        mode,
    input  logic             src_en,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             fire,
    output logic             sclk
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] cnt_dec;
    logic [DIV_W-1:0] half;

    assign cnt_dec = cnt - 1'b1;
    assign half    = divisor >> 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            fire <= 1'b0;
            sclk <= 1'b1;
        end else if (restart) begin
            cnt  <= divisor - 1'b1;
            fire <= 1'b0;
            sclk <= 1'b1;
        end else begin
            unique case (mode)
                MD_OFF: begin
                    fire <= 1'b0;
                    sclk <= 1'b1;
                end
                MD_BYPASS: begin
                    fire <= src_en;
                    if (src_en) sclk <= ~sclk;
                end
                MD_DIVIDE: begin
                    fire <= 1'b0;
                    if (src_en) begin
                        if (cnt == '0) begin
                            cnt  <= divisor - 1'b1;
                            fire <= 1'b1;
                            sclk <= 1'b1;
                        end else begin
                            cnt  <= cnt_dec;
                            sclk <= (cnt_dec >= half);
                        end
                    end
                end
                MD_PASS: begin
                    fire <= src_en;
                end
                default: fire <= 1'b0;
            endcase
        end
    end

    AST_BYPASS_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_BYPASS && src_en && !restart) |=> fire); // R6

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_OFF && !restart) |=> !fire); // R5

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src_sel,
    input  logic             sync_mode,
    input  logic [DIV_W-1:0] divisor,
    input  logic             div_wr,
    input  logic             clk_out_en,
    input  logic             pre_div_en,
    input  logic             slow_clk,
    input  logic             ext_clk,
    output logic             baud_tick,
    output logic             over_tick,
    output logic             serial_clk_out,
    output logic             serial_clk_oe
);
    localparam int SUB_W   = $clog2(OVS);
    localparam int N_ASYNC = 2;

    logic [N_ASYNC-1:0] async_vec;
    logic [N_ASYNC-1:0] sync_lvl;
    logic [N_ASYNC-1:0] sync_rise;

    assign async_vec = {ext_clk, slow_clk};

    for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
        baud_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (async_vec[g]),
            .level    (sync_lvl[g]),
            .rise     (sync_rise[g])
        );
    end

    logic src_en;
    baud_src_select u_sel (
        .sel       (src_sel),
        .pre_en    (pre_div_en),
        .slow_rise (sync_rise[0]),
        .ext_rise  (sync_rise[1]),
        .src_en    (src_en)
    );

    div_mode_e next_mode, state_q;
    logic      restart;

    always_comb begin
        next_mode = pick_mode(sync_mode, src_sel,
                              divisor == '0, divisor == DIV_W'(1));
        restart   = div_wr || (state_q != next_mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MD_OFF;
        else        state_q <= next_mode;
    end

    logic fire;
    logic sclk;
    baud_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (state_q),
        .src_en  (src_en),
        .restart (restart),
        .divisor (divisor),
        .fire    (fire),
        .sclk    (sclk)
    );

    logic             sync_q;
    logic             oe_q;
    logic [SUB_W-1:0] sub_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            oe_q   <= 1'b0;
            sub_q  <= '0;
        end else begin
            sync_q <= sync_mode;
            oe_q   <= clk_out_en & ~src_sel[1];
            if (restart)
                sub_q <= '0;
            else if (fire && !sync_q)
                sub_q <= (sub_q == SUB_W'(OVS-1)) ? '0 : sub_q + 1'b1;
        end
    end

    always_comb begin
        baud_tick      = fire & (sync_q | (sub_q == SUB_W'(OVS-1)));
        over_tick      = fire & ~sync_q;
        serial_clk_out = (state_q == MD_PASS) ? sync_lvl[1] : sclk;
        serial_clk_oe  = oe_q;
    end

    AST_QUIET_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        sync_mode |=> !over_tick); // R3

    AST_BAUD_ON_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && !sync_q) |-> over_tick); // R2

    AST_OE_EXT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel[1] |=> !serial_clk_oe); // R8

    AST_OFF_NO_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MD_OFF && !restart) |=> !baud_tick); // R5

endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = 2'b00;
    logic        sync_mode = 1'b0;
    logic [15:0] divisor = 16'd0;
    logic        div_wr = 1'b0;
    logic        clk_out_en = 1'b0;
    logic        pre_div_en = 1'b0;
    logic        slow_clk = 1'b0;
    logic        ext_clk = 1'b0;
    logic        baud_tick, over_tick, serial_clk_out, serial_clk_oe;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    baud_tick_gen u0 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .sync_mode(sync_mode),
        .divisor(divisor), .div_wr(div_wr), .clk_out_en(clk_out_en),
        .pre_div_en(pre_div_en), .slow_clk(slow_clk), .ext_clk(ext_clk),
        .baud_tick(baud_tick), .over_tick(over_tick),
        .serial_clk_out(serial_clk_out), .serial_clk_oe(serial_clk_oe)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // source stimulus: pre-divided enable every 3 cycles, slow period 10, external period 12
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            pre_div_en = (k % 3 == 0);
            k++;
        end
    end
    initial forever begin repeat (5) @(negedge clk); slow_clk = ~slow_clk; end
    initial forever begin repeat (6) @(negedge clk); ext_clk = ~ext_clk; end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic sm, input int cd);
        @(negedge clk);
        src_sel = sel; sync_mode = sm; divisor = 16'(cd); div_wr = 1'b1;
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    task automatic wait_baud(output int stamp);
        int n = 0;
        stamp = -1;
        while (n < 5000 && stamp < 0) begin
            @(negedge clk);
            n++;
            if (baud_tick) stamp = cyc;
        end
    endtask

    task automatic wait_over(output int stamp);
        int n = 0;
        stamp = -1;
        while (n < 5000 && stamp < 0) begin
            @(negedge clk);
            n++;
            if (over_tick) stamp = cyc;
        end
    endtask

    task automatic baud_period(input int exp, input string req);
        int t0, t1, t2;
        wait_baud(t0); wait_baud(t1); wait_baud(t2);
        chk((t1 >= 0) && (t2 - t1 == exp), req, t2 - t1, exp);
    endtask

    task automatic over_period(input int exp, input string req);
        int t0, t1, t2;
        wait_over(t0); wait_over(t1); wait_over(t2);
        chk((t1 >= 0) && (t2 - t1 == exp), req, t2 - t1, exp);
    endtask

    task automatic count_ticks(input int n, output int nb, output int no);
        nb = 0; no = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (baud_tick) nb++;
            if (over_tick) no++;
        end
    endtask

    initial begin
        int mult, nb, no, hi, tg;
        logic prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state: divisor 0 -> nothing out, pad not driven
        chk(!baud_tick && !over_tick, "R5 reset", baud_tick, 0);
        chk(!serial_clk_oe, "R8 reset", serial_clk_oe, 0);

        // R1 R2 R3: sweep of modes, internal sources, divisors
        for (int sm = 0; sm < 2; sm++) begin
            for (int s = 0; s < 3; s++) begin
                mult = (s == 0) ? 1 : (s == 1) ? 3 : 10;
                for (int cd = 1; cd <= 4; cd++) begin
                    cfg(2'(s), 1'(sm), cd);
                    if (sm == 1) begin
                        baud_period(mult * cd, "R3 R1 sync period");
                        count_ticks(40, nb, no);
                        chk(no == 0, "R3 over silent", no, 0);
                    end else begin
                        baud_period(16 * mult * cd, "R2 R1 async baud period");
                        if (cd >= 2) over_period(mult * cd, "R2 over period");
                        else over_period(mult, "R6 bypass over period");
                    end
                end
            end
        end

        // R4: external pass-through ignores divisor
        cfg(2'b11, 1'b1, 0); baud_period(12, "R4 ext cd=0");
        cfg(2'b11, 1'b1, 1); baud_period(12, "R4 ext cd=1");
        cfg(2'b11, 1'b1, 5); baud_period(12, "R4 ext cd=5");
        // async with external source: divisor applies
        cfg(2'b11, 1'b0, 2); baud_period(384, "R1 ext async");

        // R5: divisor 0 silences internal sources in both modes
        cfg(2'b00, 1'b1, 0); count_ticks(200, nb, no);
        chk(nb == 0 && no == 0, "R5 sync cd=0", nb + no, 0);
        cfg(2'b00, 1'b0, 0); count_ticks(200, nb, no);
        chk(nb == 0 && no == 0, "R5 async cd=0", nb + no, 0);

        // R6: bypass, tick every cycle, clock toggles every cycle
        cfg(2'b00, 1'b1, 1);
        repeat (2) @(negedge clk);
        nb = 0; tg = 0; prev = serial_clk_out;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (baud_tick) nb++;
            if (serial_clk_out != prev) tg++;
            prev = serial_clk_out;
        end
        chk(nb == 8, "R6 bypass ticks", nb, 8);
        chk(tg == 8, "R6 bypass toggles", tg, 8);

        // R7: write strobe restarts the count
        cfg(2'b00, 1'b1, 200);
        repeat (50) @(negedge clk);
        divisor = 16'd7; div_wr = 1'b1;
        @(posedge clk); nb = 0;
        @(negedge clk); div_wr = 1'b0;
        while (!baud_tick && nb < 1000) begin @(posedge clk); nb++; @(negedge clk); end
        chk(nb == 7, "R7 sync reload latency", nb, 7);
        cfg(2'b00, 1'b0, 100);
        repeat (30) @(negedge clk);
        divisor = 16'd2; div_wr = 1'b1;
        @(posedge clk); nb = 0;
        @(negedge clk); div_wr = 1'b0;
        while (!baud_tick && nb < 1000) begin @(posedge clk); nb++; @(negedge clk); end
        chk(nb == 32, "R7 async reload latency", nb, 32);

        // R9: duty cycle for even divisors
        for (int cd = 4; cd <= 6; cd += 2) begin
            cfg(2'b00, 1'b1, cd);
            repeat (3) @(negedge clk);
            hi = 0;
            for (int i = 0; i < cd * 10; i++) begin
                @(negedge clk);
                if (serial_clk_out) hi++;
            end
            chk(hi == cd * 5, "R9 duty", hi, cd * 5);
        end

        // R8: output enable truth table
        for (int en = 0; en < 2; en++) begin
            for (int s = 0; s < 4; s++) begin
                @(negedge clk);
                clk_out_en = 1'(en); src_sel = 2'(s);
                @(negedge clk);
                chk(serial_clk_oe == ((en == 1) && (s < 2)), "R8 oe",
                    serial_clk_oe, ((en == 1) && (s < 2)));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule